// File: doc/BRIEF.md
# SAR converter serial readout port

This block is the digital side of the serial port of an 18-bit sampling converter. It runs on a fast system clock. It samples the three host pins through a two-flop edge detector: the conversion strobe, the serial clock and the serial data input. A rising edge on the conversion strobe starts a conversion of fixed length. The same edge latches the interface mode from the level of the serial data input. When the conversion ends, the block captures the result word from an input port and presents it on the serial output, most significant bit first. The output advances by one bit on each falling edge of the serial clock.

The port has two modes. In chip-select mode, a low level on either the strobe or the data input enables the output. An optional busy flag is armed when the host holds the port selected at the moment the conversion completes. In daisy-chain mode, the data input becomes a serial input. Bits arriving there follow the block's own word on the output, so that several converters can share one return line. The tri-state driver is represented by an output-enable signal.

Top module: `sar_serial_port`

## Requirements
- R1: During and after reset, with no conversion run yet, `sdo_oe_o` and `sdo_o` are 0.
- R2: The level of `sdi_i` at a rising edge of `cnv_i` picks the mode for that cycle: 0 selects daisy-chain mode and 1 selects chip-select mode.
- R3: A conversion lasts `CONV_CYCLES` system clocks. Further rising edges of `cnv_i` during a conversion do not restart it, and falling edges of `sclk_i` during a conversion do not shift the output.
- R4: The result word is captured from `result_i` in the cycle the conversion completes. Each readout returns that conversion, and later changes of `result_i` do not affect it.
- R5: In chip-select mode the output is enabled only while `sdi_i` or `cnv_i` is low. While deselected, `sdo_oe_o` is 0 and falling edges of `sclk_i` do not advance the word.
- R6: The first bit presented is bit 17 (MSB). Each falling edge of `sclk_i` while enabled presents the next lower bit.
- R7: If the port is selected when the conversion completes, the busy flag is armed. While selected during the conversion, `sdo_o` is 0 with `sdo_oe_o` at 1. At completion `sdo_o` becomes 1 for one bit time, and the first falling edge of `sclk_i` then presents the MSB.
- R8: In chip-select mode the output enable drops after the falling edge that ends the last bit. That is the 18th falling edge without the busy flag, or the 19th with it.
- R9: In daisy-chain mode the output is enabled while `cnv_i` is low. The value of `sdi_i` captured at falling edge j appears on `sdo_o` after falling edge j+17 (without the busy flag), so the upstream bits follow the block's own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Conversion strobe, rising edge starts a conversion |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Mode select, chip select, or daisy-chain data input |
| result_i | input | WIDTH | Result word captured at conversion completion |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable of the serial data driver |

## Verification
A change of the select level reaches `sdo_oe_o` two clock edges after the pin changes: one edge for the input flop and one for the output register. An edge of the serial clock reaches `sdo_o` three edges after the pin changes, because the state register sits in between. A completed conversion is visible on the output about `CONV_CYCLES` plus three clocks after the strobe edge. The bench drives each pin on a falling clock edge and samples at least six clocks later. It waits `CONV_CYCLES` plus twelve clocks after a strobe before it checks a readout. In this way every check falls after the result is settled and before the next stimulus.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef struct packed {
    logic cnv;
    logic sclk;
    logic sdi;
  } pins_t;
endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync
  import sar_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pins_t pins_i,
  output pins_t lvl_o,
  output pins_t rise_o,
  output pins_t fall_o
);
  pins_t s1, s2;

  // On reset both stages take the pin level, so no false edge appears.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= pins_i;
      s2 <= pins_i;
    end else begin
      s1 <= pins_i;
      s2 <= s1;
    end
  end

  assign lvl_o  = s1;
  assign rise_o = s1 & ~s2;
  assign fall_o = ~s1 & s2;
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt    <= CW'(CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy_o <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt == '0);
endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter #(
  parameter int WIDTH = 18,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             arm_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             shift_i,
  input  logic             sin_i,
  output logic             bit_o,
  output logic [CNT_W-1:0] rem_o
);
  logic [WIDTH:0] sh;
  logic           armed;

  // Slot WIDTH holds the busy flag; without it the word starts at WIDTH-1,
  // which makes the daisy-chain delay one word length either way.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      armed <= 1'b0;
      rem_o <= '0;
    end else if (load_i) begin
      sh    <= {1'b1, word_i};
      armed <= arm_i;
      rem_o <= arm_i ? CNT_W'(WIDTH + 1) : CNT_W'(WIDTH);
    end else if (shift_i) begin
      sh <= {sh[WIDTH-1:0], sin_i};
      if (rem_o != '0) rem_o <= rem_o - 1'b1;
    end
  end

  assign bit_o = armed ? sh[WIDTH] : sh[WIDTH-1];
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int CONV_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnv_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int CNT_W = $clog2(WIDTH + 2);

  pins_t            raw, lvl, rise, fall;
  logic             conv_busy, done, start;
  logic             reading, mode_dc, sel_now;
  logic             shift, out_bit, sdo_nx, oe_nx;
  logic [CNT_W-1:0] rem;

  assign raw = '{cnv: cnv_i, sclk: sclk_i, sdi: sdi_i};

  sar_pin_sync u_sync (
    .clk(clk), .rst(rst), .pins_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign start = rise.cnv && !conv_busy;

  sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(start),
    .busy_o(conv_busy), .done_o(done)
  );

  // Select: daisy-chain uses the strobe only; chip-select uses either pin low.
  assign sel_now = mode_dc ? !lvl.cnv : (!lvl.sdi || !lvl.cnv);
  assign shift   = reading && fall.sclk && sel_now && (mode_dc || rem != '0);

  sar_out_shifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .load_i(done), .arm_i(sel_now), .word_i(result_i),
    .shift_i(shift), .sin_i(lvl.sdi),
    .bit_o(out_bit), .rem_o(rem)
  );

  always_comb begin
    if (conv_busy) begin
      sdo_nx = 1'b0;
      oe_nx  = sel_now;
    end else begin
      sdo_nx = reading ? out_bit : 1'b0;
      oe_nx  = reading && sel_now && (mode_dc || rem != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reading  <= 1'b0;
      mode_dc  <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (start) begin
        mode_dc <= !lvl.sdi;
        reading <= 1'b0;
      end else if (done) begin
        reading <= 1'b1;
      end
      sdo_o    <= sdo_nx;
      sdo_oe_o <= oe_nx;
    end
  end
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
  parameter int WIDTH       = 18,
  parameter int CONV_CYCLES = 64,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_busy,
  input logic             done,
  input logic             reading,
  input logic             mode_dc,
  input logic [CNT_W-1:0] rem,
  input logic             sdo_o,
  input logic             sdo_oe_o
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst || !conv_busy) run_len <= 0;
    else                   run_len <= run_len + 1;
  end

  // R3: a conversion spans exactly CONV_CYCLES clocks
  a_r3_conv_len: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_busy) |-> run_len == CONV_CYCLES);

  // R3: no shifting while the conversion runs
  a_r3_rem_hold: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && !done) |=> $stable(rem));

  // R7: output held low through the conversion
  a_r7_low_in_conv: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && $past(conv_busy)) |-> !sdo_o);

  // R8: chip-select enable drops once the word is spent
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (reading && !mode_dc && rem == '0) |=> !sdo_oe_o);

  // R6: bit counter never exceeds word plus busy slot
  a_r6_rem_range: assert property (@(posedge clk) disable iff (rst)
    rem <= CNT_W'(WIDTH + 1));

  // R1: with no conversion and no readout the driver stays off
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!conv_busy && !reading) |=> !sdo_oe_o);
endmodule

bind sar_serial_port sar_serial_port_chk #(
  .WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_busy(conv_busy), .done(done),
  .reading(reading), .mode_dc(mode_dc), .rem(rem),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/tb_sar_serial_port.sv
module tb_sar_serial_port;
  localparam int W    = 18;
  localparam int CONV = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnv = 1'b1, sclk = 1'b0, sdi = 1'b1;
  logic [W-1:0] result = '0;
  logic         sdo, sdo_oe;
  int           checks = 0, fails = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  sar_serial_port #(.WIDTH(W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sclk_i(sclk), .sdi_i(sdi),
    .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sfall();
    sclk = 1'b1; wt(4);
    sclk = 1'b0; wt(6);
  endtask

  task automatic start_conv(logic cs);
    sdi = cs; cnv = 1'b0; wt(6);
    cnv = 1'b1;
  endtask

  // chip-select mode, deselected at completion: no busy flag
  task automatic cs_plain(logic [W-1:0] res);
    result = res;
    start_conv(1'b1);
    wt(CONV + 12);
    chk("R5 deselected after conversion oe", sdo_oe, 0);
    result = ~res;
    cnv = 1'b0; wt(6);
    chk("R5 selected by strobe low oe", sdo_oe, 1);
    chk("R6 R4 first bit is MSB", sdo, res[W-1]);
    for (int j = 1; j <= W; j++) begin
      sfall();
      if (j < W) chk("R6 bit after fall", sdo, res[W-1-j]);
      else       chk("R8 release after last fall", sdo_oe, 0);
    end
    cnv = 1'b1;
    wt(CONV + 12);
  endtask

  // chip-select via sdi during conversion: busy flag armed
  task automatic cs_busy(logic [W-1:0] res);
    result = res;
    start_conv(1'b1);
    wt(4);
    sdi = 1'b0; wt(6);
    chk("R7 low during conversion oe", sdo_oe, 1);
    chk("R7 low during conversion sdo", sdo, 0);
    sfall(); sfall();
    cnv = 1'b0; wt(3);
    cnv = 1'b1;
    wt(CONV + 4);
    chk("R3 R7 busy flag high oe", sdo_oe, 1);
    chk("R3 R7 busy flag high sdo", sdo, 1);
    for (int j = 1; j <= W + 1; j++) begin
      sfall();
      if (j == 7) begin
        sdi = 1'b1; wt(6);
        chk("R5 deselect drops oe", sdo_oe, 0);
        sfall();
        sdi = 1'b0; wt(6);
        chk("R5 reselect oe", sdo_oe, 1);
      end
      if (j <= W) chk("R7 R6 bit after busy flag", sdo, res[W-j]);
      else        chk("R8 release after flag plus word", sdo_oe, 0);
    end
    sdi = 1'b1; wt(6);
  endtask

  // daisy-chain mode, upstream pattern follows own word
  task automatic dc_chain(logic [W-1:0] res, logic [23:0] pat);
    result = res;
    start_conv(1'b0);
    wt(CONV + 12);
    chk("R9 strobe high keeps oe off", sdo_oe, 0);
    cnv = 1'b0; wt(6);
    chk("R9 strobe low enables", sdo_oe, 1);
    chk("R9 R6 own MSB first", sdo, res[W-1]);
    for (int k = 1; k <= 24; k++) begin
      sclk = 1'b1; sdi = pat[k-1]; wt(4);
      sclk = 1'b0; wt(6);
      if (k < W) chk("R9 own bit", sdo, res[W-1-k]);
      else begin
        chk("R2 R9 chained bit", sdo, pat[k-W]);
        chk("R2 R9 stays enabled", sdo_oe, 1);
      end
    end
    sdi = 1'b1; cnv = 1'b1; wt(6);
    chk("R9 strobe high releases", sdo_oe, 0);
    wt(CONV + 12);
  endtask

  initial begin
    wt(5);
    chk("R1 reset oe", sdo_oe, 0);
    chk("R1 reset sdo", sdo, 0);
    rst = 1'b0; wt(4);
    chk("R1 idle oe", sdo_oe, 0);
    chk("R1 idle sdo", sdo, 0);
    cs_plain('0);
    cs_plain('1);
    for (int i = 1; i <= 8; i++)
      cs_plain(W'((i * 32'h9E37) ^ (i << 11) ^ 32'h2A5A5));
    cs_busy(W'(32'h2AAAA));
    cs_busy(W'(32'h15555));
    cs_busy(W'(32'h3C0F1));
    dc_chain(W'(32'h1F0E3), 24'hC3A5F1);
    dc_chain(W'(32'h20001), 24'h5A0F96);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule